// File: doc/BRIEF.md
# Serial Peripheral Target with Select Resynchronization

This block is the target (slave) side of an 8-bit SPI link. It never makes a clock. A remote controller drives the serial clock, the data-in line and an active-low select line. The block shifts one byte in and one byte out on each run of eight clock cycles, most significant bit first. Each completed receive byte is copied into a receive buffer and announced by a one-cycle completion pulse. The byte to send comes from a transmit buffer that the local side writes.

The three serial inputs pass through two-flop synchronizers into the system clock domain, and the clock edges are found there. The system clock must run at least four times faster than the serial clock. A 4-bit mode code selects one of three behaviours. With select control on, the select line gates all activity, drives the output-enable and puts the bit counter back to zero whenever it is high. With select ignored, the block shifts on every clock edge. Any other code holds the shift engine idle. Polarity and phase inputs cover the four usual SPI clock modes. A receive-only input keeps the data output released so that the block can share one wire for data in and data out.

Top module: `spi_tgt_xcvr`

## Requirements
- R1: After reset, sdo_oe_o, done_o, rx_full_o, rx_ovf_o and wcol_o are 0 and rx_data_o is 8'h00.
- R2: Eight sample edges complete a byte. The bits received MSB first appear on rx_data_o in the same cycle as a one-cycle pulse on done_o. rx_data_o changes only in a cycle where done_o is high.
- R3: sdo_o presents the transmit buffer MSB first, one bit for each byte position, so the controller reads back the byte that was written.
- R4: The idle level of the serial clock equals cpol_i. With cke_i=1 the block samples on the leading edge (idle to active) and shifts out on the trailing edge. With cke_i=0 the block shifts out on every leading edge except the first of a byte and samples on the trailing edge.
- R5: mode_i=4'b0100 enables select control and mode_i=4'b0101 ignores ss_ni, with sdo_oe_o high. Any other code keeps sdo_oe_o low and produces no done_o.
- R6: With mode 4'b0100, sdo_oe_o is low in the same cycle that ss_ni is high, even partway through a byte.
- R7: With mode 4'b0100, a high level on select discards the partial byte and clears the bit count, so the next byte after select falls is received aligned.
- R8: With cke_i=1 and mode 4'b0100, the falling edge of ss_ni at once enables sdo_o carrying the transmit buffer MSB.
- R9: While out_dis_i=1, sdo_oe_o stays low and reception continues.
- R10: A tx_wr_i while a byte is in progress sets wcol_o and leaves the transmit buffer unchanged.
- R11: A byte that completes while rx_full_o=1 sets rx_ovf_o and leaves rx_data_o unchanged.
- R12: rx_rd_i clears rx_full_o. flag_clr_i clears wcol_o and rx_ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Mode code: 0100 select on, 0101 select ignored |
| cpol_i | input | 1 | Serial clock idle level |
| cke_i | input | 1 | 1: sample on leading edge, data set up before it |
| out_dis_i | input | 1 | Receive-only, keeps data output released |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | 8 | Transmit buffer write data |
| rx_rd_i | input | 1 | Receive buffer consumed, clears rx_full_o |
| flag_clr_i | input | 1 | Clears wcol_o and rx_ovf_o |
| sclk_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Select, active low |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for the sdo pad |
| rx_data_o | output | 8 | Receive buffer |
| done_o | output | 1 | One-cycle byte completion pulse |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| rx_ovf_o | output | 1 | Byte lost because the buffer was full |
| wcol_o | output | 1 | Transmit write collided with a shift |

## Verification
The hardest cases to reach from the ports need an event partway through a byte: select rising after only a few bits, and a transmit write landing while the shift engine is busy. A single driver task takes a bit count and a bit position at which to fire a write. It can therefore stop a byte early or inject a colliding write at a chosen point, and then run a clean byte that shows the counter was realigned and the buffer kept its old value. Overflow is reached by not consuming the first byte before the second one completes. The scoreboard then expects the old byte again.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam logic [3:0] MODE_SEL   = 4'b0100;
  localparam logic [3:0] MODE_NOSEL = 4'b0101;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else             st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic idle_i,
  output logic lead_o,
  output logic trail_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  // leading = leaving idle level, trailing = returning to it
  assign lead_o  = (lvl_i != prev_q) && (prev_q == idle_i);
  assign trail_o = (lvl_i != prev_q) && (prev_q != idle_i);
endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          samp_i,
  input  logic          shft_i,
  input  logic          shft_starts_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] load_i,
  output logic          sdo_bit_o,
  output logic          busy_o,
  output logic          fin_o,
  output logic [DW-1:0] word_o
);
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [DW-1:0] rxsr_q, txsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rxsr_q <= '0;
      txsr_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rxsr_q <= '0;
      txsr_q <= load_i;
    end else begin
      if (!busy_q) txsr_q <= load_i;  // idle: keep MSB presented
      if (samp_i) begin
        rxsr_q <= {rxsr_q[DW-2:0], sdi_i};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          busy_q <= 1'b1;
        end
      end else if (shft_i) begin
        if (busy_q)             txsr_q <= {txsr_q[DW-2:0], 1'b0};
        else if (shft_starts_i) busy_q <= 1'b1;
      end
    end
  end

  assign sdo_bit_o = txsr_q[DW-1];
  assign busy_o    = busy_q;
  assign fin_o     = samp_i && !clr_i && (cnt_q == LAST);
  assign word_o    = {rxsr_q[DW-2:0], sdi_i};
endmodule

// File: rtl/spi_tgt_xcvr.sv
module spi_tgt_xcvr
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    mode_i,
  input  logic          cpol_i,
  input  logic          cke_i,
  input  logic          out_dis_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_rd_i,
  input  logic          flag_clr_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          ss_ni,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          done_o,
  output logic          rx_full_o,
  output logic          rx_ovf_o,
  output logic          wcol_o
);
  logic [2:0] pins_s;
  logic sclk_s, sdi_s, ss_s;
  logic lead, trail, samp, shft;
  logic en, sel_mode, eng_clr;
  logic busy, fin;
  logic [DW-1:0] word;
  logic [DW-1:0] tx_buf_q, rx_buf_q;
  logic done_q, full_q, ovf_q, wcol_q;

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sdi_i, sclk_i}),
    .q_o   (pins_s)
  );
  assign {ss_s, sdi_s, sclk_s} = pins_s;

  spi_tgt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sclk_s),
    .idle_i (cpol_i),
    .lead_o (lead),
    .trail_o(trail)
  );

  assign en       = (mode_i == MODE_SEL) || (mode_i == MODE_NOSEL);
  assign sel_mode = (mode_i == MODE_SEL);
  assign eng_clr  = !en || (sel_mode && ss_s);
  assign samp     = cke_i ? lead  : trail;
  assign shft     = cke_i ? trail : lead;

  spi_tgt_engine #(.DW(DW)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (eng_clr),
    .samp_i       (samp),
    .shft_i       (shft),
    .shft_starts_i(!cke_i),
    .sdi_i        (sdi_s),
    .load_i       (tx_buf_q),
    .sdo_bit_o    (sdo_o),
    .busy_o       (busy),
    .fin_o        (fin),
    .word_o       (word)
  );

  // raw select pin: release without synchronizer delay
  assign sdo_oe_o = en && !out_dis_i && !(sel_mode && ss_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q <= '0;
      wcol_q   <= 1'b0;
    end else begin
      if (flag_clr_i) wcol_q <= 1'b0;
      if (tx_wr_i) begin
        if (busy) wcol_q   <= 1'b1;
        else      tx_buf_q <= tx_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q <= '0;
      done_q   <= 1'b0;
      full_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      done_q <= fin;
      if (flag_clr_i) ovf_q <= 1'b0;
      if (fin) begin
        if (full_q) ovf_q <= 1'b1;
        else begin
          rx_buf_q <= word;
          full_q   <= 1'b1;
        end
      end else if (rx_rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign rx_data_o = rx_buf_q;
  assign done_o    = done_q;
  assign rx_full_o = full_q;
  assign rx_ovf_o  = ovf_q;
  assign wcol_o    = wcol_q;
endmodule

// File: rtl/spi_tgt_xcvr_chk.sv
module spi_tgt_xcvr_chk
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    mode_i,
  input logic          ss_ni,
  input logic          out_dis_i,
  input logic          tx_wr_i,
  input logic          sdo_oe_o,
  input logic          done_o,
  input logic          rx_full_o,
  input logic          rx_ovf_o,
  input logic          wcol_o,
  input logic [DW-1:0] rx_data_o
);
  logic legal;
  assign legal = (mode_i == MODE_SEL) || (mode_i == MODE_NOSEL);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  rx_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> done_o);

  // R5
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legal && $past(!legal)) |-> (!sdo_oe_o && !done_o));

  // R6
  sel_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SEL && ss_ni) |-> !sdo_oe_o);

  // R9
  rx_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |-> !sdo_oe_o);

  // R10
  wcol_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_o) |-> $past(tx_wr_i));

  // R11
  ovf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(rx_full_o)) |-> $stable(rx_data_o));

  // R11
  ovf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> done_o);
endmodule

bind spi_tgt_xcvr spi_tgt_xcvr_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .ss_ni    (ss_ni),
  .out_dis_i(out_dis_i),
  .tx_wr_i  (tx_wr_i),
  .sdo_oe_o (sdo_oe_o),
  .done_o   (done_o),
  .rx_full_o(rx_full_o),
  .rx_ovf_o (rx_ovf_o),
  .wcol_o   (wcol_o),
  .rx_data_o(rx_data_o)
);

// File: tb/spi_tgt_xcvr_test.sv
`timescale 1ns/1ps
module spi_tgt_xcvr_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] mode_i = 4'h0;
  logic cpol_i = 1'b0, cke_i = 1'b0, out_dis_i = 1'b0;
  logic tx_wr_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic rx_rd_i = 1'b0, flag_clr_i = 1'b0;
  logic sclk_i = 1'b0, sdi_i = 1'b0, ss_ni = 1'b1;
  logic sdo_o, sdo_oe_o, done_o, rx_full_o, rx_ovf_o, wcol_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  spi_tgt_xcvr uut (.*);

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected rx bytes on every completion
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected done", rx_data_o, 8'hxx);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data_o == e, "R2 rx byte", rx_data_o, e);
      end
    end
  end

  task automatic pulse(ref logic sig);
    @(negedge clk_i); sig = 1'b1;
    @(negedge clk_i); sig = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] v);
    @(negedge clk_i); tx_data_i = v; tx_wr_i = 1'b1;
    @(negedge clk_i); tx_wr_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic cfg(input logic [3:0] m, input logic cp, input logic ck);
    mode_i = 4'h0; ss_ni = 1'b1;
    cpol_i = cp; sclk_i = cp; cke_i = ck;
    #64; mode_i = m; #32;
  endtask

  // driver: nbits bits, optional colliding write after bit wr_at
  task automatic xfer(input logic [7:0] mosi, input int nbits, input int wr_at,
                      input bit chk_miso, input logic [7:0] exp_miso, input string req);
    logic [7:0] got = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (cke_i) begin
        sdi_i = mosi[7-i]; #32; got[7-i] = sdo_o;
        sclk_i = ~cpol_i; #32; sclk_i = cpol_i;
      end else begin
        sclk_i = ~cpol_i; sdi_i = mosi[7-i]; #32; got[7-i] = sdo_o;
        sclk_i = cpol_i; #32;
      end
      if (i == wr_at) begin
        #16;
        @(negedge clk_i); tx_data_i = 8'hFF; tx_wr_i = 1'b1;
        @(negedge clk_i); tx_wr_i = 1'b0;
      end
    end
    #32;
    if (chk_miso && nbits == 8) chk(got == exp_miso, req, got, exp_miso);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #10;
    @(negedge clk_i);
    // R1 reset state
    chk(sdo_oe_o == 1'b0 && done_o == 1'b0, "R1 oe/done", {6'd0, sdo_oe_o, done_o}, 8'h00);
    chk(rx_data_o == 8'h00, "R1 rx_data", rx_data_o, 8'h00);
    chk({rx_full_o, rx_ovf_o, wcol_o} == 3'b000, "R1 flags", {5'd0, rx_full_o, rx_ovf_o, wcol_o}, 8'h00);
    rst_ni = 1'b1;
    #20;

    // R3 R4: all four clock modes, select control on
    for (int m = 0; m < 4; m++) begin
      logic [7:0] tv, rv;
      tv = 8'hA5 ^ 8'(m * 8'h1D);
      rv = 8'h3C + 8'(m * 8'h41);
      cfg(4'b0100, m[1], m[0]);
      wr_tx(tv);
      exp_q.push_back(rv);
      ss_ni = 1'b0; #64;
      xfer(rv, 8, -1, 1'b1, tv, "R3 R4 sdo byte");
      ss_ni = 1'b1; pulse(rx_rd_i);
      chk(rx_full_o == 1'b0, "R12 rd clears full", {7'd0, rx_full_o}, 8'h00);
    end

    // R8: cke=1 select fall presents MSB at once
    cfg(4'b0100, 1'b0, 1'b1);
    wr_tx(8'h96);
    chk(sdo_oe_o == 1'b0, "R6 released while select high", {7'd0, sdo_oe_o}, 8'h00);
    ss_ni = 1'b0; #1;
    chk(sdo_oe_o == 1'b1 && sdo_o == 1'b1, "R8 MSB on select fall", {6'd0, sdo_oe_o, sdo_o}, 8'h03);

    // R6 R7: abort after 4 bits, then aligned byte
    #64;
    xfer(8'hF0, 4, -1, 1'b0, 8'h00, "R7");
    ss_ni = 1'b1; #1;
    chk(sdo_oe_o == 1'b0, "R6 mid-byte release", {7'd0, sdo_oe_o}, 8'h00);
    #64;
    exp_q.push_back(8'h81);
    ss_ni = 1'b0; #64;
    xfer(8'h81, 8, -1, 1'b1, 8'h96, "R7 aligned sdo after abort");
    ss_ni = 1'b1; pulse(rx_rd_i);

    // R9: receive-only
    out_dis_i = 1'b1;
    exp_q.push_back(8'h5E);
    ss_ni = 1'b0; #64;
    chk(sdo_oe_o == 1'b0, "R9 oe forced low", {7'd0, sdo_oe_o}, 8'h00);
    xfer(8'h5E, 8, -1, 1'b0, 8'h00, "R9");
    ss_ni = 1'b1; pulse(rx_rd_i); out_dis_i = 1'b0;

    // R10: colliding write
    cfg(4'b0100, 1'b0, 1'b0);
    wr_tx(8'h5A);
    exp_q.push_back(8'h0F);
    ss_ni = 1'b0; #64;
    xfer(8'h0F, 8, 2, 1'b1, 8'h5A, "R10 current shift intact");
    chk(wcol_o == 1'b1, "R10 wcol set", {7'd0, wcol_o}, 8'h01);
    pulse(rx_rd_i);
    exp_q.push_back(8'hE7);
    xfer(8'hE7, 8, -1, 1'b1, 8'h5A, "R10 tx buffer unchanged");
    pulse(rx_rd_i);

    // R11: overflow keeps old byte
    exp_q.push_back(8'h22);
    xfer(8'h22, 8, -1, 1'b0, 8'h00, "R11");
    exp_q.push_back(8'h22);
    xfer(8'h33, 8, -1, 1'b0, 8'h00, "R11");
    chk(rx_ovf_o == 1'b1 && rx_data_o == 8'h22, "R11 ovf keeps data", rx_data_o, 8'h22);
    pulse(rx_rd_i); pulse(flag_clr_i);
    chk({rx_full_o, rx_ovf_o, wcol_o} == 3'b000, "R12 flags cleared", {5'd0, rx_full_o, rx_ovf_o, wcol_o}, 8'h00);
    ss_ni = 1'b1;

    // R5: select ignored
    cfg(4'b0101, 1'b0, 1'b0);
    chk(sdo_oe_o == 1'b1, "R5 oe with select ignored", {7'd0, sdo_oe_o}, 8'h01);
    exp_q.push_back(8'hC3);
    xfer(8'hC3, 8, -1, 1'b1, 8'h5A, "R5 byte with select high");
    pulse(rx_rd_i);

    // R5: illegal mode does nothing
    cfg(4'b0000, 1'b0, 1'b0);
    ss_ni = 1'b0; #64;
    chk(sdo_oe_o == 1'b0, "R5 oe off in bad mode", {7'd0, sdo_oe_o}, 8'h00);
    xfer(8'h77, 8, -1, 1'b0, 8'h00, "R5");
    chk(rx_full_o == 1'b0, "R5 no byte in bad mode", {7'd0, rx_full_o}, 8'h00);
    ss_ni = 1'b1;
    #64;
    chk(exp_q.size() == 0, "R2 all bytes seen", 8'(exp_q.size()), 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule